// File: doc/BRIEF.md
# Host-to-Card DMA Descriptor Status Tracker

This block follows a single host-to-card DMA descriptor from the moment it is loaded until the moment it ends. At load time it captures three things: a 3-bit control field, a 20-bit requested byte count and a 64-bit opaque user word. While the descriptor is active, data beats arrive, each with its own byte count. The block sums the delivered bytes and produces the card-side address for every beat. On the first beat it flags start-of-packet and shows the user word in that same cycle. The DMA logic never looks inside the user word.

Read-completion events may arrive alongside the data. Each can carry any mix of three fault marks: unsuccessful completion status, poisoned payload and end-to-end CRC failure. These marks are sticky for the whole descriptor. The descriptor ends in one of two ways: the delivered count reaches the requested count, or upstream flags the last beat. At that point the block latches an 8-bit status byte and a 4-bit fault-detail nibble, and pulses a status-valid strobe. One cycle after the strobe, it raises a one-cycle interrupt if the matching enable is set. There is one enable for clean endings and a separate one for faulted endings.

Top module: `dma_desc_status`

## Requirements
- R1: While reset is active, and in the first cycles after it, `status_o`, `detail_o`, `stat_vld_o`, `irq_o` and `sop_o` are all zero.
- R2: The first beat accepted after a load raises `sop_o`, and `user_ctrl_o` shows the loaded user word in that cycle. On every other cycle `sop_o` is 0 and `user_ctrl_o` is all zeros.
- R3: When control bit 2 is 0, `card_addr_o` starts at the loaded address and advances by each accepted beat's byte count. When control bit 2 is 1, it stays at the loaded address for every beat.
- R4: A beat that brings the delivered total to or past the requested count ends the descriptor. With no fault, the status is 0x01: bit 0 (done) is set, and bit 1 (short) and bit 4 (fault) are clear. A requested count of 0 ends on the first beat.
- R5: A beat with `last_i` high ends the descriptor early. If the delivered total is below the requested count, status bit 1 (short) is set, independently of the fault bit.
- R6: If any fault mark was seen, the descriptor's status has bit 4 set and bit 0 clear. The detail nibble then records: bit 0 for unsuccessful status, bit 1 for poisoned, bit 2 for CRC error. The detail nibble is non-zero only when bit 4 is set.
- R7: Fault marks accumulate over all completions of a descriptor, including several marks in one cycle. Loading a new descriptor clears them, and also clears `status_o` and `detail_o` to zero.
- R8: Status bits 7:5 and 3:2, and detail bit 3, always read 0.
- R9: `stat_vld_o` is a one-cycle pulse in the cycle after the ending beat. `status_o` and `detail_o` hold their values until the next load.
- R10: `irq_o` pulses for one cycle, in the cycle after `stat_vld_o`. It pulses only if the relevant enable is set: control bit 0 for a clean ending, control bit 1 for a faulted ending.
- R11: Beats and completions that arrive while no descriptor is active are ignored. They produce no SOP, no strobe and no change to status.
- R12: A load while a descriptor is active restarts tracking. Marks and counts from the abandoned descriptor have no effect on the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Start a new descriptor |
| ctrl_i | input | 3 | Bit 0 clean-end IRQ enable, bit 1 fault IRQ enable, bit 2 fixed card address |
| req_bytes_i | input | 20 | Requested byte count |
| card_addr_i | input | 32 | Starting card address |
| user_ctrl_i | input | 64 | Opaque user word |
| beat_valid_i | input | 1 | Data beat present |
| beat_bytes_i | input | 7 | Bytes in this beat (0..64) |
| last_i | input | 1 | Upstream marks this beat as final |
| cpl_valid_i | input | 1 | Read completion event |
| cpl_ur_i | input | 1 | Completion had unsuccessful status |
| cpl_ep_i | input | 1 | Completion was poisoned |
| cpl_ecrc_i | input | 1 | Completion failed end-to-end CRC |
| sop_o | output | 1 | Start of packet for the current beat |
| user_ctrl_o | output | 64 | User word, valid with `sop_o` |
| card_addr_o | output | 32 | Card address for the current beat |
| status_o | output | 8 | Final descriptor status |
| detail_o | output | 4 | Fault-detail nibble |
| stat_vld_o | output | 1 | Status-valid strobe |
| irq_o | output | 1 | Interrupt pulse |

## Verification
A wrong byte total shows up at the ending beat, and sometimes earlier. The strobe then arrives a beat early or late, the short bit flips, or, in incrementing mode, `card_addr_o` drifts on the very next beat. A fault mark that is lost or left stale from an earlier descriptor appears in `status_o`/`detail_o` one cycle after the ending beat. A wrong enable selection appears on `irq_o` one cycle after that. The table walk covers clean, short, faulted and overshoot endings; the directed tests then probe idle input, restarts and reload clearing.

// File: rtl/dma_desc_pkg.sv
package dma_desc_pkg;

  // control field bit positions
  localparam int unsigned CTL_IRQ_OK  = 0;
  localparam int unsigned CTL_IRQ_ERR = 1;
  localparam int unsigned CTL_FIXED   = 2;
  localparam int unsigned CTL_W       = 3;

  // status byte bit positions
  localparam int unsigned ST_DONE  = 0;
  localparam int unsigned ST_SHORT = 1;
  localparam int unsigned ST_FAULT = 4;
  localparam int unsigned ST_W     = 8;

  // detail nibble bit positions
  localparam int unsigned DET_UR   = 0;
  localparam int unsigned DET_EP   = 1;
  localparam int unsigned DET_ECRC = 2;
  localparam int unsigned DET_W    = 4;
  localparam int unsigned MARK_W   = 3;

  typedef struct packed {
    logic ecrc;
    logic ep;
    logic ur;
  } fault_marks_t;

  function automatic logic [ST_W-1:0] pack_status(input logic fault, input logic short_f);
    logic [ST_W-1:0] s;
    s = '0;
    s[ST_DONE]  = ~fault;
    s[ST_SHORT] = short_f;
    s[ST_FAULT] = fault;
    return s;
  endfunction

  function automatic logic [DET_W-1:0] pack_detail(input fault_marks_t m);
    logic [DET_W-1:0] d;
    d = '0;
    d[DET_UR]   = m.ur;
    d[DET_EP]   = m.ep;
    d[DET_ECRC] = m.ecrc;
    return d;
  endfunction

endpackage

// File: rtl/dma_desc_track.sv
module dma_desc_track #(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BEAT_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              fixed_i,
  input  logic              beat_valid_i,
  input  logic [BEAT_W-1:0] beat_bytes_i,
  input  logic              last_i,
  output logic              active_o,
  output logic              sop_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              end_o,
  output logic              short_o
);

  localparam int unsigned TOT_W = CNT_W + 1;

  logic              active_q, active_d;
  logic              first_q, first_d;
  logic              fixed_q, fixed_d;
  logic [CNT_W-1:0]  req_q, req_d;
  logic [TOT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              take;
  logic [TOT_W-1:0]  cnt_sum;

  assign take    = active_q & ~load_i & beat_valid_i;
  assign cnt_sum = cnt_q + TOT_W'(beat_bytes_i);

  always_comb begin
    active_d = active_q;
    first_d  = first_q;
    fixed_d  = fixed_q;
    req_d    = req_q;
    cnt_d    = cnt_q;
    addr_d   = addr_q;
    end_o    = 1'b0;
    short_o  = 1'b0;
    if (load_i) begin
      active_d = 1'b1;
      first_d  = 1'b1;
      fixed_d  = fixed_i;
      req_d    = req_i;
      cnt_d    = '0;
      addr_d   = addr_i;
    end else if (take) begin
      first_d = 1'b0;
      cnt_d   = cnt_sum;
      if (!fixed_q) begin
        addr_d = addr_q + ADDR_W'(beat_bytes_i);
      end
      if (last_i || (cnt_sum >= {1'b0, req_q})) begin
        end_o    = 1'b1;
        short_o  = (cnt_sum < {1'b0, req_q});
        active_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      first_q  <= 1'b0;
      fixed_q  <= 1'b0;
      req_q    <= '0;
      cnt_q    <= '0;
      addr_q   <= '0;
    end else begin
      active_q <= active_d;
      first_q  <= first_d;
      fixed_q  <= fixed_d;
      req_q    <= req_d;
      cnt_q    <= cnt_d;
      addr_q   <= addr_d;
    end
  end

  assign active_o = active_q;
  assign sop_o    = take & first_q;
  assign addr_o   = addr_q;

endmodule

// File: rtl/dma_desc_faults.sv
module dma_desc_faults
  import dma_desc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         active_i,
  input  logic         cpl_valid_i,
  input  fault_marks_t cpl_marks_i,
  output fault_marks_t marks_nxt_o
);

  fault_marks_t marks_q, marks_d;
  logic         accept;

  assign accept = active_i & ~load_i & cpl_valid_i;

  always_comb begin
    marks_d = marks_q;
    if (load_i) begin
      marks_d = '0;
    end else if (accept) begin
      marks_d = marks_q | cpl_marks_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      marks_q <= '0;
    end else begin
      marks_q <= marks_d;
    end
  end

  // includes marks arriving in the ending cycle
  assign marks_nxt_o = marks_d;

endmodule

// File: rtl/dma_desc_report.sv
module dma_desc_report
  import dma_desc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              end_i,
  input  logic              short_i,
  input  fault_marks_t      marks_i,
  input  logic              irq_ok_en_i,
  input  logic              irq_err_en_i,
  output logic [ST_W-1:0]   status_o,
  output logic [DET_W-1:0]  detail_o,
  output logic              vld_o,
  output logic              irq_o
);

  logic [ST_W-1:0]  status_q, status_d;
  logic [DET_W-1:0] detail_q, detail_d;
  logic             vld_q, vld_d;
  logic             irq_q, irq_d;
  logic             fault;

  assign fault = |marks_i;

  always_comb begin
    status_d = status_q;
    detail_d = detail_q;
    vld_d    = 1'b0;
    irq_d    = vld_q & (status_q[ST_FAULT] ? irq_err_en_i : irq_ok_en_i);
    if (load_i) begin
      status_d = '0;
      detail_d = '0;
    end else if (end_i) begin
      status_d = pack_status(fault, short_i);
      detail_d = fault ? pack_detail(marks_i) : '0;
      vld_d    = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      detail_q <= '0;
      vld_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      detail_q <= detail_d;
      vld_q    <= vld_d;
      irq_q    <= irq_d;
    end
  end

  assign status_o = status_q;
  assign detail_o = detail_q;
  assign vld_o    = vld_q;
  assign irq_o    = irq_q;

endmodule

// File: rtl/dma_desc_status.sv
module dma_desc_status
  import dma_desc_pkg::*;
#(
  parameter int unsigned CNT_W  = 20,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned BEAT_W = 7,
  parameter int unsigned USER_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [2:0]        ctrl_i,
  input  logic [CNT_W-1:0]  req_bytes_i,
  input  logic [ADDR_W-1:0] card_addr_i,
  input  logic [USER_W-1:0] user_ctrl_i,
  input  logic              beat_valid_i,
  input  logic [BEAT_W-1:0] beat_bytes_i,
  input  logic              last_i,
  input  logic              cpl_valid_i,
  input  logic              cpl_ur_i,
  input  logic              cpl_ep_i,
  input  logic              cpl_ecrc_i,
  output logic              sop_o,
  output logic [USER_W-1:0] user_ctrl_o,
  output logic [ADDR_W-1:0] card_addr_o,
  output logic [7:0]        status_o,
  output logic [3:0]        detail_o,
  output logic              stat_vld_o,
  output logic              irq_o
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync_q[1];

  // per-descriptor control and user word
  logic [CTL_W-1:0]  ctrl_q, ctrl_d;
  logic [USER_W-1:0] user_q, user_d;

  always_comb begin
    ctrl_d = ctrl_q;
    user_d = user_q;
    if (load_i) begin
      ctrl_d = ctrl_i;
      user_d = user_ctrl_i;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ctrl_q <= '0;
      user_q <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      user_q <= user_d;
    end
  end

  logic         active, sop, end_now, short_now;
  fault_marks_t cpl_marks, marks_nxt;

  assign cpl_marks = '{ecrc: cpl_ecrc_i, ep: cpl_ep_i, ur: cpl_ur_i};

  dma_desc_track #(
    .CNT_W (CNT_W),
    .ADDR_W(ADDR_W),
    .BEAT_W(BEAT_W)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .load_i      (load_i),
    .req_i       (req_bytes_i),
    .addr_i      (card_addr_i),
    .fixed_i     (ctrl_i[CTL_FIXED]),
    .beat_valid_i(beat_valid_i),
    .beat_bytes_i(beat_bytes_i),
    .last_i      (last_i),
    .active_o    (active),
    .sop_o       (sop),
    .addr_o      (card_addr_o),
    .end_o       (end_now),
    .short_o     (short_now)
  );

  dma_desc_faults u_faults (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .load_i     (load_i),
    .active_i   (active),
    .cpl_valid_i(cpl_valid_i),
    .cpl_marks_i(cpl_marks),
    .marks_nxt_o(marks_nxt)
  );

  dma_desc_report u_report (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .load_i      (load_i),
    .end_i       (end_now),
    .short_i     (short_now),
    .marks_i     (marks_nxt),
    .irq_ok_en_i (ctrl_q[CTL_IRQ_OK]),
    .irq_err_en_i(ctrl_q[CTL_IRQ_ERR]),
    .status_o    (status_o),
    .detail_o    (detail_o),
    .vld_o       (stat_vld_o),
    .irq_o       (irq_o)
  );

  assign sop_o       = sop;
  assign user_ctrl_o = sop ? user_q : '0;

endmodule

// File: rtl/dma_desc_status_chk.sv
module dma_desc_status_chk #(
  parameter int unsigned USER_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_i,
  input logic              sop_o,
  input logic [USER_W-1:0] user_ctrl_o,
  input logic [7:0]        status_o,
  input logic [3:0]        detail_o,
  input logic              stat_vld_o,
  input logic              irq_o
);

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[7:5] == 3'b000) && (status_o[3:2] == 2'b00) && !detail_o[3]);

  p_detail_needs_fault_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|detail_o) |-> status_o[4]);

  p_done_xor_fault_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld_o |-> (status_o[0] != status_o[4]));

  p_vld_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stat_vld_o |=> !stat_vld_o);

  p_status_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_vld_o && !$past(load_i)) |-> $stable(status_o));

  p_irq_follows_vld_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> $past(stat_vld_o));

  p_irq_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  p_user_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sop_o |-> (user_ctrl_o == '0));

endmodule

bind dma_desc_status dma_desc_status_chk #(.USER_W(USER_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .load_i     (load_i),
  .sop_o      (sop_o),
  .user_ctrl_o(user_ctrl_o),
  .status_o   (status_o),
  .detail_o   (detail_o),
  .stat_vld_o (stat_vld_o),
  .irq_o      (irq_o)
);

// File: tb/dma_desc_status_tb_top.sv
module dma_desc_status_tb_top;

  logic        clk;
  logic        rst_n;
  logic        load_i;
  logic [2:0]  ctrl_i;
  logic [19:0] req_bytes_i;
  logic [31:0] card_addr_i;
  logic [63:0] user_ctrl_i;
  logic        beat_valid_i;
  logic [6:0]  beat_bytes_i;
  logic        last_i;
  logic        cpl_valid_i, cpl_ur_i, cpl_ep_i, cpl_ecrc_i;
  logic        sop_o;
  logic [63:0] user_ctrl_o;
  logic [31:0] card_addr_o;
  logic [7:0]  status_o;
  logic [3:0]  detail_o;
  logic        stat_vld_o, irq_o;

  int checks = 0;
  int errors = 0;

  dma_desc_status dut_i (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .ctrl_i(ctrl_i),
    .req_bytes_i(req_bytes_i), .card_addr_i(card_addr_i), .user_ctrl_i(user_ctrl_i),
    .beat_valid_i(beat_valid_i), .beat_bytes_i(beat_bytes_i), .last_i(last_i),
    .cpl_valid_i(cpl_valid_i), .cpl_ur_i(cpl_ur_i), .cpl_ep_i(cpl_ep_i),
    .cpl_ecrc_i(cpl_ecrc_i), .sop_o(sop_o), .user_ctrl_o(user_ctrl_o),
    .card_addr_o(card_addr_o), .status_o(status_o), .detail_o(detail_o),
    .stat_vld_o(stat_vld_o), .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // marks: bit0 unsuccessful, bit1 poisoned, bit2 CRC
  typedef struct packed {
    logic [2:0]  ctrl;
    logic [19:0] req;
    logic [7:0]  nbeats;
    logic [6:0]  bytes;
    logic [2:0]  mark_first;
    logic [2:0]  mark_last;
    logic        early;
    logic [7:0]  exp_status;
    logic [3:0]  exp_detail;
    logic        exp_irq;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{3'b001, 20'd64,  8'd4, 7'd16, 3'b000, 3'b000, 1'b0, 8'h01, 4'h0, 1'b1},
    '{3'b000, 20'd64,  8'd4, 7'd16, 3'b000, 3'b000, 1'b0, 8'h01, 4'h0, 1'b0},
    '{3'b010, 20'd100, 8'd2, 7'd32, 3'b000, 3'b000, 1'b1, 8'h03, 4'h0, 1'b0},
    '{3'b011, 20'd48,  8'd3, 7'd16, 3'b001, 3'b000, 1'b0, 8'h10, 4'h1, 1'b1},
    '{3'b001, 20'd48,  8'd3, 7'd16, 3'b010, 3'b100, 1'b0, 8'h10, 4'h6, 1'b0},
    '{3'b010, 20'd40,  8'd1, 7'd64, 3'b000, 3'b111, 1'b0, 8'h10, 4'h7, 1'b1},
    '{3'b111, 20'd32,  8'd1, 7'd16, 3'b100, 3'b000, 1'b1, 8'h12, 4'h4, 1'b1},
    '{3'b100, 20'd0,   8'd1, 7'd8,  3'b000, 3'b000, 1'b0, 8'h01, 4'h0, 1'b0}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    load_i = 0; beat_valid_i = 0; last_i = 0; beat_bytes_i = '0;
    cpl_valid_i = 0; cpl_ur_i = 0; cpl_ep_i = 0; cpl_ecrc_i = 0;
  endtask

  task automatic do_load(input logic [2:0] c, input logic [19:0] r, input logic [31:0] a, input logic [63:0] u);
    @(negedge clk);
    idle_inputs();
    load_i = 1; ctrl_i = c; req_bytes_i = r; card_addr_i = a; user_ctrl_i = u;
    @(negedge clk);
    load_i = 0;
  endtask

  task automatic drive_beat(input logic [6:0] b, input logic lst, input logic [2:0] mk);
    beat_valid_i = 1; beat_bytes_i = b; last_i = lst;
    cpl_valid_i = |mk; cpl_ur_i = mk[0]; cpl_ep_i = mk[1]; cpl_ecrc_i = mk[2];
  endtask

  task automatic run_vec(input int k);
    vec_t v;
    logic [31:0] base, aexp;
    logic [63:0] uw;
    v = VECS[k];
    base = 32'h0001_0000 + 32'(k) * 32'h100;
    uw = 64'hC0DE_0000_0000_0000 | 64'(k);
    aexp = base;
    do_load(v.ctrl, v.req, base, uw);
    #1;
    check(status_o == 8'h00 && detail_o == 4'h0, "R7 load clears status", {status_o, detail_o}, 0);
    for (int b = 0; b < int'(v.nbeats); b++) begin
      logic [2:0] mk;
      mk = 3'b000;
      if (b == 0) mk = mk | v.mark_first;
      if (b == int'(v.nbeats) - 1) mk = mk | v.mark_last;
      drive_beat(v.bytes, v.early && (b == int'(v.nbeats) - 1), mk);
      #1;
      check(sop_o == (b == 0), "R2 sop on first beat only", sop_o, b == 0);
      if (b == 0) check(user_ctrl_o == uw, "R2 user word with sop", user_ctrl_o, uw);
      else        check(user_ctrl_o == 0, "R2 user word gated", user_ctrl_o, 0);
      check(card_addr_o == aexp, "R3 card address", card_addr_o, aexp);
      check(stat_vld_o == 0, "R9 no strobe before end", stat_vld_o, 0);
      if (!v.ctrl[2]) aexp = aexp + 32'(v.bytes);
      @(negedge clk);
      idle_inputs();
    end
    #1;
    check(stat_vld_o == 1, "R9 strobe after ending beat", stat_vld_o, 1);
    check(status_o == v.exp_status, "R4 R5 R6 status byte", status_o, v.exp_status);
    check(detail_o == v.exp_detail, "R6 R7 detail nibble", detail_o, v.exp_detail);
    check(irq_o == 0, "R10 irq not with strobe", irq_o, 0);
    @(negedge clk); #1;
    check(irq_o == v.exp_irq, "R10 irq gating", irq_o, v.exp_irq);
    check(stat_vld_o == 0, "R9 strobe one cycle", stat_vld_o, 0);
    check(status_o == v.exp_status, "R9 status held", status_o, v.exp_status);
    @(negedge clk); #1;
    check(irq_o == 0, "R10 irq one cycle", irq_o, 0);
  endtask

  initial begin : watchdog
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    ctrl_i = '0; req_bytes_i = '0; card_addr_i = '0; user_ctrl_i = '0;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    #1;
    check({status_o, detail_o, stat_vld_o, irq_o, sop_o} == 0, "R1 outputs in reset",
          {status_o, detail_o, stat_vld_o, irq_o, sop_o}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    check({status_o, detail_o, stat_vld_o, irq_o, sop_o} == 0, "R1 outputs after release",
          {status_o, detail_o, stat_vld_o, irq_o, sop_o}, 0);
    repeat (3) @(negedge clk);

    for (int k = 0; k < NVEC; k++) run_vec(k);

    // R11: idle beats and faulted completions are ignored; last status 0x01 held
    @(negedge clk);
    drive_beat(7'd32, 1'b1, 3'b111);
    #1;
    check(sop_o == 0, "R11 no sop while idle", sop_o, 0);
    @(negedge clk); idle_inputs(); #1;
    check(stat_vld_o == 0, "R11 no strobe while idle", stat_vld_o, 0);
    check(status_o == 8'h01 && detail_o == 0, "R11 status unchanged", {status_o, detail_o}, 12'h010);
    @(negedge clk); #1;
    check(irq_o == 0, "R11 no irq while idle", irq_o, 0);

    // R12: restart mid-descriptor discards old marks and bytes
    do_load(3'b011, 20'd64, 32'h2000, 64'h1111);
    drive_beat(7'd32, 1'b0, 3'b011);
    @(negedge clk); idle_inputs();
    do_load(3'b001, 20'd32, 32'h3000, 64'h2222);
    drive_beat(7'd32, 1'b0, 3'b000);
    #1;
    check(sop_o == 1 && user_ctrl_o == 64'h2222, "R12 restart gives new sop", user_ctrl_o, 64'h2222);
    check(card_addr_o == 32'h3000, "R12 restart address", card_addr_o, 32'h3000);
    @(negedge clk); idle_inputs(); #1;
    check(stat_vld_o == 1 && status_o == 8'h01, "R12 clean status after restart", status_o, 8'h01);
    check(detail_o == 4'h0, "R12 old marks dropped", detail_o, 0);
    @(negedge clk); #1;
    check(irq_o == 1, "R10 clean irq after restart", irq_o, 1);

    // R7: marks accumulate across cycles, then clear on reload
    do_load(3'b000, 20'd48, 32'h4000, 64'h3);
    drive_beat(7'd16, 1'b0, 3'b001);
    @(negedge clk); idle_inputs();
    cpl_valid_i = 1; cpl_ecrc_i = 1;
    @(negedge clk); idle_inputs();
    drive_beat(7'd32, 1'b0, 3'b000);
    @(negedge clk); idle_inputs(); #1;
    check(status_o == 8'h10 && detail_o == 4'h5, "R7 marks accumulate", {status_o, detail_o}, 12'h105);
    do_load(3'b000, 20'd16, 32'h5000, 64'h4);
    #1;
    check(status_o == 0 && detail_o == 0, "R7 reload clears", {status_o, detail_o}, 0);
    drive_beat(7'd16, 1'b0, 3'b000);
    @(negedge clk); idle_inputs(); #1;
    check(status_o == 8'h01 && detail_o == 0, "R7 fresh descriptor clean", {status_o, detail_o}, 12'h010);

    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule